// File: doc/BRIEF.md
# Operand Bypass and Interlock Controller for a Six-Stage Register-Memory Pipeline

This controller sits beside a pipeline whose stages run fetch, decode/register read, address generation (AG), memory access (MEM), execute (EX) and write-back (WB). One instruction can enter every clock. The controller takes the decoded fields of the instruction currently in decode: its operation class, base register, two source registers and destination. It keeps a short record of every instruction still in flight. From these records it drives the datapath multiplexer selects that route results from younger stages back to the operands that need them.

Operands travel down the pipeline in latches. When an older instruction writes back, any younger in-flight operand that names the same register can load the write-back value: on its way out of AG, on its way out of MEM, or straight into the EX inputs. Store data in MEM can also take the combinational EX output. The AG adder is the only consumer that can be too early for its producer. In that case the controller raises `stall`, which holds fetch and decode and sends a bubble into AG.

Top module: `fwd_stall_unit`

## Requirements
- R1: While reset is asserted (`rst_n` low, asynchronous), and in the first cycles after it, no stage holds an instruction. `stall` and every select are 0, and a base-using instruction in decode does not stall.
- R2: `ex_a_wb` / `ex_b_wb` are 1 in the cycle an EX operand names the destination of the instruction immediately ahead of it, which is then in WB.
- R3: `mem_a_wb` / `mem_b_wb` are 1 when the instruction in MEM names, as an EX operand, the destination of the instruction two ahead, which is then in WB. This holds with any unrelated instruction in between.
- R4: `ag_a_wb`, `ag_b_wb` and `ag_sd_wb` are 1 when the instruction in AG names, as an EX operand or as store data, the destination of the instruction three ahead, which is then in WB.
- R5: A producer four ahead is in WB while its consumer reads the register file. The same-clock write-through covers it, so there is no stall and no select.
- R6: `stall` is 1 while a valid base-using instruction in decode names the destination of a writer in AG or MEM. This gives 2 stall cycles for a producer one ahead and 1 for a producer two ahead. Each stall cycle puts a bubble into AG, and `stall` never stays high for more than 2 cycles in a row.
- R7: `ag_base_wb` is 1 when the instruction in AG uses a base register that the instruction in WB writes. This covers the first AG cycle after a base stall.
- R8: `mem_sd_sel` applies to a store in MEM: 2 takes the EX output (producer one ahead), 1 takes the WB value (producer two ahead), 0 keeps the carried latch. When both producers match, the younger one wins. Store data never causes a stall, and the value 3 never appears.
- R9: Only the classes register-register ALU, register-memory ALU and load count as writers. The destination fields of stores, branches and no-ops never cause a stall or a select.
- R10: `id_op` encodes 0 no-op, 1 register-register ALU, 2 register-memory ALU, 3 load, 4 store and 5 branch. Register-register ALU uses srca and srcb. Register-memory ALU uses base and srca (srcb is ignored, because its operand comes from memory). Load uses base (srca is ignored). Store uses base, with srca as its data. Branch uses srca and srcb and no base.
- R11: When `id_valid` is 0 the decode slot is empty. It never stalls, and its fields are not tracked as a writer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| id_valid | input | 1 | Decode slot holds an instruction |
| id_op | input | 3 | Operation class (R10) |
| id_base | input | RW | Base register for address generation |
| id_srca | input | RW | First source (EX operand A or store data) |
| id_srcb | input | RW | Second source (EX operand B) |
| id_dst | input | RW | Destination register |
| stall | output | 1 | Hold fetch and decode, bubble into AG |
| ag_base_wb | output | 1 | AG base input takes the WB value |
| ag_a_wb | output | 1 | Operand A latch leaving AG loads the WB value |
| ag_b_wb | output | 1 | Operand B latch leaving AG loads the WB value |
| ag_sd_wb | output | 1 | Store-data latch leaving AG loads the WB value |
| mem_a_wb | output | 1 | Operand A latch leaving MEM loads the WB value |
| mem_b_wb | output | 1 | Operand B latch leaving MEM loads the WB value |
| mem_sd_sel | output | 2 | Store-data source in MEM (R8) |
| ex_a_wb | output | 1 | EX input A takes the WB value |
| ex_b_wb | output | 1 | EX input B takes the WB value |

## Verification
The bench places producers one, two, three and four slots ahead of their consumers. An off-by-one in stage alignment would therefore light the wrong stage's select or miss the operand altogether. Base stalls are counted cycle by cycle for the one-ahead and two-ahead cases. A design that stalls too briefly would feed a stale base to the adder, and one that stalls too long would lose throughput. Stores with two matching producers check that the younger EX result beats the WB value. Stores, branches, invalid slots and ignored fields are given destinations that collide with later sources, so a design that compares without the writer and use gating would show false stalls or selects.

// File: rtl/fwd_stall_unit.sv
module fwd_stall_unit #(
  parameter int NREG = 32,
  localparam int RW = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          id_valid,
  input  logic [2:0]    id_op,
  input  logic [RW-1:0] id_base,
  input  logic [RW-1:0] id_srca,
  input  logic [RW-1:0] id_srcb,
  input  logic [RW-1:0] id_dst,
  output logic          stall,
  output logic          ag_base_wb,
  output logic          ag_a_wb,
  output logic          ag_b_wb,
  output logic          ag_sd_wb,
  output logic          mem_a_wb,
  output logic          mem_b_wb,
  output logic [1:0]    mem_sd_sel,
  output logic          ex_a_wb,
  output logic          ex_b_wb
);

  localparam logic [2:0] OP_RR = 3'd1;
  localparam logic [2:0] OP_RM = 3'd2;
  localparam logic [2:0] OP_LD = 3'd3;
  localparam logic [2:0] OP_ST = 3'd4;
  localparam logic [2:0] OP_BR = 3'd5;

  typedef struct packed {
    logic          v;
    logic [2:0]    op;
    logic [RW-1:0] a;
    logic [RW-1:0] b;
    logic [RW-1:0] d;
  } slot_t;

  function automatic logic writes(input logic [2:0] op);
    return op == OP_RR || op == OP_RM || op == OP_LD;
  endfunction

  function automatic logic uses_base(input logic [2:0] op);
    return op == OP_RM || op == OP_LD || op == OP_ST;
  endfunction

  function automatic logic uses_a(input logic [2:0] op);
    return op == OP_RR || op == OP_RM || op == OP_BR;
  endfunction

  function automatic logic uses_b(input logic [2:0] op);
    return op == OP_RR || op == OP_BR;
  endfunction

  slot_t         ag_q, mem_q, ex_q;
  logic [RW-1:0] ag_base_q;
  logic          wb_wr_q;
  logic [RW-1:0] wb_d_q;

  logic ag_wr, mem_wr, ex_wr;
  assign ag_wr  = ag_q.v  && writes(ag_q.op);
  assign mem_wr = mem_q.v && writes(mem_q.op);
  assign ex_wr  = ex_q.v  && writes(ex_q.op);

  assign stall = id_valid && uses_base(id_op) &&
                 ((ag_wr && ag_q.d == id_base) || (mem_wr && mem_q.d == id_base));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ag_q      <= '0;
      mem_q     <= '0;
      ex_q      <= '0;
      ag_base_q <= '0;
      wb_wr_q   <= 1'b0;
      wb_d_q    <= '0;
    end else begin
      ag_q      <= stall ? '0 : slot_t'{v: id_valid, op: id_op, a: id_srca, b: id_srcb, d: id_dst};
      ag_base_q <= id_base;
      mem_q     <= ag_q;
      ex_q      <= mem_q;
      wb_wr_q   <= ex_wr;
      wb_d_q    <= ex_q.d;
    end
  end

  assign ag_base_wb = ag_q.v && uses_base(ag_q.op) && wb_wr_q && wb_d_q == ag_base_q;
  assign ag_a_wb    = ag_q.v && uses_a(ag_q.op)    && wb_wr_q && wb_d_q == ag_q.a;
  assign ag_b_wb    = ag_q.v && uses_b(ag_q.op)    && wb_wr_q && wb_d_q == ag_q.b;
  assign ag_sd_wb   = ag_q.v && ag_q.op == OP_ST   && wb_wr_q && wb_d_q == ag_q.a;

  assign mem_a_wb = mem_q.v && uses_a(mem_q.op) && wb_wr_q && wb_d_q == mem_q.a;
  assign mem_b_wb = mem_q.v && uses_b(mem_q.op) && wb_wr_q && wb_d_q == mem_q.b;

  always_comb begin
    mem_sd_sel = 2'd0;
    if (mem_q.v && mem_q.op == OP_ST) begin
      if (ex_wr && ex_q.d == mem_q.a)          mem_sd_sel = 2'd2;
      else if (wb_wr_q && wb_d_q == mem_q.a)   mem_sd_sel = 2'd1;
    end
  end

  assign ex_a_wb = ex_q.v && uses_a(ex_q.op) && wb_wr_q && wb_d_q == ex_q.a;
  assign ex_b_wb = ex_q.v && uses_b(ex_q.op) && wb_wr_q && wb_d_q == ex_q.b;

endmodule

// File: rtl/fwd_stall_unit_chk.sv
module fwd_stall_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       id_valid,
  input logic       stall,
  input logic       ag_v,
  input logic       ag_base_wb,
  input logic [1:0] mem_sd_sel
);

  AST_IDLE_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n) !id_valid |-> !stall); // R11
  AST_STALL_RUN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n) (stall && $past(stall)) |=> !stall); // R6
  AST_BUBBLE_AFTER_STALL: assert property (@(posedge clk) disable iff (!rst_n) stall |=> !ag_v); // R6
  AST_NO_BASE_FWD_ON_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n) $past(stall) |-> !ag_base_wb); // R7
  AST_SD_SEL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n) mem_sd_sel != 2'd3); // R8

endmodule

bind fwd_stall_unit fwd_stall_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .id_valid(id_valid), .stall(stall),
  .ag_v(ag_q.v), .ag_base_wb(ag_base_wb), .mem_sd_sel(mem_sd_sel)
);

// File: tb/fwd_stall_unit_test.sv
`timescale 1ns/1ps
module fwd_stall_unit_test;
  localparam int RW = 5;
  localparam logic [2:0] NOP = 3'd0, RR = 3'd1, RM = 3'd2, LD = 3'd3, ST = 3'd4, BR = 3'd5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic id_valid;
  logic [2:0] id_op;
  logic [RW-1:0] id_base, id_srca, id_srcb, id_dst;
  logic stall, ag_base_wb, ag_a_wb, ag_b_wb, ag_sd_wb, mem_a_wb, mem_b_wb, ex_a_wb, ex_b_wb;
  logic [1:0] mem_sd_sel;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  fwd_stall_unit uut (.*);

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(logic v, logic [2:0] op, int base, int a, int b, int d);
    @(posedge clk); #1;
    id_valid = v; id_op = op;
    id_base = RW'(base); id_srca = RW'(a); id_srcb = RW'(b); id_dst = RW'(d);
    @(negedge clk);
  endtask

  task automatic idle();
    cyc(0, NOP, 0, 0, 0, 0);
  endtask

  task automatic flush();
    for (int i = 0; i < 5; i++) idle();
  endtask

  task automatic t_reset();
    chk("R1", "stall in reset", stall, 0);
    chk("R1", "ag_base_wb in reset", ag_base_wb, 0);
    chk("R1", "mem_sd_sel in reset", mem_sd_sel, 0);
    chk("R1", "ex_a_wb in reset", ex_a_wb, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    cyc(1, LD, 1, 0, 0, 2);
    chk("R1", "stall after reset", stall, 0);
    flush();
  endtask

  task automatic t_ex_fwd();
    cyc(1, RR, 0, 1, 2, 5);
    cyc(1, RR, 0, 5, 5, 6);
    idle();
    idle(); chk("R2", "mem_a_wb early", mem_a_wb, 0);
    idle(); chk("R2", "ex_a_wb", ex_a_wb, 1); chk("R2", "ex_b_wb", ex_b_wb, 1);
    idle(); chk("R2", "ex_a_wb after", ex_a_wb, 0);
    flush();
  endtask

  task automatic t_mem_fwd();
    cyc(1, RR, 0, 1, 2, 7);
    cyc(1, RR, 0, 1, 2, 9);
    cyc(1, RR, 0, 3, 7, 10);
    idle();
    idle(); chk("R3", "mem_b_wb", mem_b_wb, 1); chk("R3", "mem_a_wb", mem_a_wb, 0);
    chk("R3", "ex_a_wb unrelated", ex_a_wb, 0);
    idle(); chk("R3", "ex_b_wb later", ex_b_wb, 0);
    flush();
  endtask

  task automatic t_ag_capture();
    cyc(1, RR, 0, 1, 2, 7);
    idle(); idle();
    cyc(1, RR, 0, 7, 7, 12);
    idle(); chk("R4", "ag_a_wb", ag_a_wb, 1); chk("R4", "ag_b_wb", ag_b_wb, 1);
    flush();
    cyc(1, LD, 1, 0, 0, 8);
    idle(); idle();
    cyc(1, ST, 2, 8, 0, 0);
    idle(); chk("R4", "ag_sd_wb", ag_sd_wb, 1); chk("R4", "ag_base_wb no match", ag_base_wb, 0);
    idle(); chk("R8", "mem_sd_sel carried", mem_sd_sel, 0);
    flush();
  endtask

  task automatic t_rf_write_through();
    cyc(1, RR, 0, 1, 1, 2);
    idle(); idle(); idle();
    cyc(1, LD, 2, 0, 0, 9); chk("R5", "stall four ahead", stall, 0);
    idle(); chk("R5", "ag_base_wb four ahead", ag_base_wb, 0);
    flush();
  endtask

  task automatic t_base_stall_one();
    int n = 0;
    cyc(1, LD, 1, 0, 0, 3);
    for (int i = 0; i < 3; i++) begin
      cyc(1, LD, 3, 0, 0, 4);
      if (stall) n++;
      if (i == 0) chk("R6", "stall cycle 1", stall, 1);
      if (i == 1) chk("R6", "stall cycle 2", stall, 1);
      if (i == 2) chk("R6", "stall released", stall, 0);
    end
    chk("R6", "stall count one ahead", n, 2);
    idle(); chk("R7", "ag_base_wb after stall", ag_base_wb, 1);
    flush();
  endtask

  task automatic t_base_stall_two();
    cyc(1, RR, 0, 1, 1, 3);
    cyc(1, RR, 0, 1, 2, 9);
    cyc(1, ST, 3, 4, 0, 0); chk("R6", "stall two ahead", stall, 1);
    cyc(1, ST, 3, 4, 0, 0); chk("R6", "released two ahead", stall, 0);
    idle(); chk("R7", "ag_base_wb", ag_base_wb, 1); chk("R7", "ag_sd_wb", ag_sd_wb, 0);
    flush();
  endtask

  task automatic t_store_data();
    cyc(1, LD, 1, 0, 0, 4);
    cyc(1, RR, 0, 1, 2, 4);
    cyc(1, ST, 3, 4, 0, 0); chk("R8", "store no stall", stall, 0);
    idle();
    idle(); chk("R8", "younger wins", mem_sd_sel, 2);
    flush();
    cyc(1, RR, 0, 1, 2, 8);
    idle();
    cyc(1, ST, 5, 8, 0, 0);
    idle();
    idle(); chk("R8", "from wb", mem_sd_sel, 1);
    flush();
  endtask

  task automatic t_no_false_match();
    cyc(1, ST, 1, 2, 0, 5);
    cyc(1, RR, 0, 5, 5, 7);
    cyc(1, BR, 0, 1, 2, 5);
    cyc(1, LD, 5, 0, 0, 6); chk("R9", "branch dst no stall", stall, 0);
    idle(); chk("R9", "store dst ex_a_wb", ex_a_wb, 0); chk("R9", "store dst ex_b_wb", ex_b_wb, 0);
    flush();
    cyc(1, NOP, 0, 0, 0, 4);
    cyc(1, LD, 4, 0, 0, 1); chk("R9", "nop dst no stall", stall, 0);
    flush();
  endtask

  task automatic t_field_use();
    cyc(1, RR, 0, 1, 2, 6);
    cyc(1, BR, 6, 1, 2, 0); chk("R10", "branch base ignored", stall, 0);
    flush();
    cyc(1, RR, 0, 1, 2, 6);
    cyc(1, LD, 1, 6, 6, 9);
    idle(); idle();
    idle(); chk("R10", "load srca ignored", ex_a_wb, 0); chk("R10", "load srcb ignored", ex_b_wb, 0);
    flush();
    cyc(1, RR, 0, 1, 2, 6);
    cyc(1, RM, 2, 3, 6, 10);
    idle(); idle();
    idle(); chk("R10", "rm srcb ignored", ex_b_wb, 0);
    flush();
    cyc(1, RR, 0, 1, 2, 6);
    cyc(1, RM, 2, 6, 0, 10);
    idle(); idle();
    idle(); chk("R10", "rm srca used", ex_a_wb, 1);
    flush();
    cyc(1, RR, 0, 1, 2, 6);
    cyc(1, RM, 6, 1, 0, 10); chk("R10", "rm base stalls", stall, 1);
    flush();
    cyc(1, RR, 0, 1, 2, 11);
    cyc(1, BR, 0, 12, 11, 0);
    idle(); idle();
    idle(); chk("R10", "branch srcb used", ex_b_wb, 1); chk("R10", "branch srca", ex_a_wb, 0);
    flush();
  endtask

  task automatic t_invalid();
    cyc(1, RR, 0, 1, 1, 3);
    cyc(0, LD, 3, 0, 0, 5); chk("R11", "invalid no stall", stall, 0);
    cyc(1, LD, 5, 0, 0, 1); chk("R11", "invalid dst untracked", stall, 0);
    flush();
  endtask

  initial begin
    id_valid = 0; id_op = NOP; id_base = '0; id_srca = '0; id_srcb = '0; id_dst = '0;
    #1;
    t_reset();
    t_ex_fwd();
    t_mem_fwd();
    t_ag_capture();
    t_rf_write_through();
    t_base_stall_one();
    t_base_stall_two();
    t_store_data();
    t_no_false_match();
    t_field_use();
    t_invalid();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule